// File: doc/BRIEF.md
# Registered Five-Function Integer ALU

This block is the arithmetic and logic unit of a simple single-cycle integer core. It takes two operands of `WIDTH` bits (32 by default) and a 3-bit operation code. It returns a result word and a flag that is high when the result is all zeros. The branch-if-equal path uses that flag after a subtract.

Five operations are defined: bitwise AND, bitwise OR, addition, subtraction and signed set-less-than. Subtract and set-less-than share one adder. Bit 2 of the operation code inverts the second operand and supplies the carry-in. The three unused codes give a result of zero.

Both outputs are registered, so a result appears one clock after its operands are presented. A synchronous active-high reset clears the output register.

Top module: `alu_core`

## Requirements
- R1: Operation code 3'b000 gives the bitwise AND of A and B.
- R2: Operation code 3'b001 gives the bitwise OR of A and B.
- R3: Operation code 3'b010 gives A + B modulo 2^WIDTH. The carry out of the top bit is discarded.
- R4: Operation code 3'b110 gives A - B modulo 2^WIDTH.
- R5: Operation code 3'b111 compares A and B as signed two's-complement numbers. The result is 1 when A < B and 0 otherwise, with all upper bits zero. The answer is correct even when A - B overflows.
- R6: Operation codes 3'b011, 3'b100 and 3'b101 give a result of zero, whatever the operands are.
- R7: `zero_o` is 1 exactly when `result_o` is all zeros.
- R8: The result for the operands and code sampled at a rising clock edge appears on `result_o` and `zero_o` just after that edge and holds for one cycle. There is no other latency.
- R9: When `rst` is high at a rising edge, `result_o` becomes 0 and `zero_o` becomes 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Registered all-zero flag of the result |

## Verification
The bench concentrates on set-less-than at the sign boundaries, for example the most positive value against the most negative. A design that reads only the sign of the difference gives the inverted answer there. It also runs addition that wraps to zero and subtraction of equal operands, which check the carry-in handling and the zero flag. A design that forgets the carry-in is off by one, and a wrong flag would make the branch go the wrong way.

The three unused codes are driven with non-zero operands. A decoder that falls through to a neighbouring operation leaks a non-zero value on those codes. Back-to-back operations and a reset in the middle of a run catch an extra register stage or a reset that does not clear the output.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // bit of the code that turns the adder into a subtractor
  localparam int unsigned SUB_BIT = 2;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/alu_slt.sv
module alu_slt (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic diff_msb_i,
  output logic lt_o
);
  // differing signs: the negative operand is the smaller one; the difference can overflow
  always_comb begin
    if (a_msb_i != b_msb_i) lt_o = a_msb_i;
    else                    lt_o = diff_msb_i;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_or_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb y_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] addsub_y;
  logic [WIDTH-1:0] logic_y;
  logic             lt;
  logic [WIDTH-1:0] next_y;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op_i[SUB_BIT]),
    .sum_o (addsub_y)
  );

  alu_slt u_slt (
    .a_msb_i    (a_i[MSB]),
    .b_msb_i    (b_i[MSB]),
    .diff_msb_i (addsub_y[MSB]),
    .lt_o       (lt)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_or_i (op_i[0]),
    .y_o      (logic_y)
  );

  always_comb begin
    unique case (op_i)
      OP_AND, OP_OR:  next_y = logic_y;
      OP_ADD, OP_SUB: next_y = addsub_y;
      OP_SLT:         next_y = {{(WIDTH-1){1'b0}}, lt};
      default:        next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= next_y;
      zero_o   <= (next_y == '0);
    end
  end

  // R1
  a_r1_and: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b000) |=> result_o == $past(a_i & b_i));
  // R2
  a_r2_or: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b001) |=> result_o == $past(a_i | b_i));
  // R3
  a_r3_add: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010) |=> result_o == $past(a_i + b_i));
  // R4
  a_r4_sub: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b110) |=> result_o == $past(a_i - b_i));
  // R5
  a_r5_slt: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b111) |=> result_o == {{(WIDTH-1){1'b0}}, $past($signed(a_i) < $signed(b_i))});
  // R6
  a_r6_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) |=> (result_o == '0 && zero_o));
  // R7
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));
  // R9
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (result_o == '0 && zero_o));
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] res;
    logic         z;
    logic [7:0]   req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] result;
  logic         zero;
  logic         drv_valid = 1'b0;
  int           n_chk = 0, n_bad = 0;
  exp_t         sb_q[$];
  bit           done = 1'b0;

  always #5 clk = ~clk;

  alu_core #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .zero_o(zero)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic [2:0] o);
    case (o)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return x + y;
      3'b110:  return x - y;
      3'b111:  return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [2:0] o, input logic [7:0] req);
    exp_t e;
    @(negedge clk);
    a = x; b = y; op = o; drv_valid = 1'b1;
    e.res = model(x, y, o);
    e.z   = (e.res == '0);
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    drv_valid = 1'b0;
  endtask

  task automatic check(input string name, input logic [W-1:0] act, input logic act_z,
                       input logic [W-1:0] exp_r, input logic exp_z);
    n_chk++;
    if (act !== exp_r || act_z !== exp_z) begin
      n_bad++;
      $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
               name, act, act_z, exp_r, exp_z);
    end
  endtask

  // monitor: pops one expected item per cycle in which the driver presented operands
  initial begin
    forever begin
      logic pend;
      exp_t e;
      @(posedge clk);
      pend = drv_valid && !rst;
      #2;
      if (pend) begin
        e = sb_q.pop_front();
        check($sformatf("R%0d_R7_R8", e.req), result, zero, e.res, e.z);
      end
    end
  end

  initial begin
    #500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset state", result, zero, '0, 1'b1);
    rst = 1'b0;
    // R1 AND
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000, 1);
    apply(32'hAAAA_AAAA, 32'h5555_5555, 3'b000, 1);
    // R2 OR
    apply(32'hF000_0001, 32'h0000_0F00, 3'b001, 2);
    apply(32'h0, 32'h0, 3'b001, 2);
    // R3 ADD incl. wrap to zero
    apply(32'd100, 32'd23, 3'b010, 3);
    apply(32'hFFFF_FFFF, 32'h1, 3'b010, 3);
    apply(32'h7FFF_FFFF, 32'h1, 3'b010, 3);
    // R4 SUB incl. equal operands and negative result
    apply(32'd500, 32'd500, 3'b110, 4);
    apply(32'd3, 32'd10, 3'b110, 4);
    apply(32'h8000_0000, 32'h1, 3'b110, 4);
    // R5 SLT incl. overflow corners
    apply(32'hFFFF_FFFF, 32'h1, 3'b111, 5);
    apply(32'h1, 32'hFFFF_FFFF, 3'b111, 5);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 5);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, 5);
    apply(32'h1234, 32'h1234, 3'b111, 5);
    apply(32'd5, 32'd9, 3'b111, 5);
    // R6 undefined codes with non-zero operands
    apply(32'hFFFF_FFFF, 32'h1234_5678, 3'b011, 6);
    apply(32'hFFFF_FFFF, 32'h1234_5678, 3'b100, 6);
    apply(32'h8000_0000, 32'h0000_0001, 3'b101, 6);
    idle();
    // R9 reset mid-run clears a non-zero result
    apply(32'hDEAD_BEEF, 32'h0, 3'b001, 2);
    idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run reset", result, zero, '0, 1'b1);
    rst = 1'b0;
    // R8 back-to-back after reset
    apply(32'h1, 32'h2, 3'b010, 8);
    apply(32'h3, 32'h3, 3'b110, 8);
    idle();
    repeat (2) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule